// File: doc/BRIEF.md
# Measurement Accumulator With Shift Averaging

This block sits after a pulse-width or edge-count measurement counter and collects its results. Each time the upstream counter finishes a measurement it presents the value with a one-cycle valid strobe. The block adds a batch of `2^N` such readings, where `N` is a programmed exponent. The same adder serves width readings (the sum is then the total asserted time at the selected polarity) and frequency readings.

When the last reading of a batch arrives, the block latches the total and the average. The average is the total shifted right by `N`, so no divider is needed. It then checks both values against their own programmed reference, each with a symmetric margin. The outcomes go into four sticky flags, a pass and a fail for the sum and for the average. These flags survive later batches and restarts, and only reset clears them.

A restart input drops the partial batch so that measurement can be realigned to a trigger. A free-running counter records every reading accepted since reset.

Top module: `meas_accum`

## Requirements
- R1: After reset, `batch_done`, `sum_out`, `avg_out`, `meas_count` and all four flags are zero.
- R2: With exponent N, the block adds exactly 2^N accepted readings. `batch_done` is high in the cycle after the edge that accepts the last of them, and `sum_out` then holds their total. A new batch starts from zero.
- R3: `avg_out` equals the batch total shifted right by N, truncated. Both outputs are loaded at the same time.
- R4: An exponent above `MAX_EXP` acts as `MAX_EXP`.
- R5: The sum passes when `sum_ref - sum_margin <= total <= sum_ref + sum_margin`, with both bounds inclusive. A completed batch sets `sum_pass` if it passes, and sets `sum_fail` if it does not.
- R6: The average is checked in the same way against `avg_ref` and `avg_margin`, and the result sets `avg_pass` or `avg_fail`.
- R7: All four flags are sticky. Once set, they stay high until reset.
- R8: A high `restart` discards the partial sum and the reading position, and it wins over a reading strobed in the same cycle. It changes neither the flags, `meas_count`, `sum_out` nor `avg_out`.
- R9: `meas_count` rises by one for each accepted reading and wraps modulo 2^CNT_W.
- R10: `batch_done` is high only in a cycle that follows an accepted reading. `sum_out` and `avg_out` hold their values between batches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Drop partial batch |
| sample_vld | input | 1 | Reading valid strobe |
| sample_val | input | VAL_W | Reading value |
| num_exp | input | EXP_W | Batch size exponent N (2^N readings) |
| sum_ref | input | VAL_W+MAX_EXP | Sum reference |
| sum_margin | input | VAL_W+MAX_EXP | Sum margin |
| avg_ref | input | VAL_W | Average reference |
| avg_margin | input | VAL_W | Average margin |
| batch_done | output | 1 | Batch completed last cycle |
| sum_out | output | VAL_W+MAX_EXP | Last batch total |
| avg_out | output | VAL_W | Last batch average |
| sum_pass | output | 1 | Sticky sum in-window flag |
| sum_fail | output | 1 | Sticky sum out-of-window flag |
| avg_pass | output | 1 | Sticky average in-window flag |
| avg_fail | output | 1 | Sticky average out-of-window flag |
| meas_count | output | CNT_W | Accepted reading count |

## Verification
The bench builds the block with `VAL_W=8`, `MAX_EXP=2` and `CNT_W=4`. With a two-bit exponent, the value 3 lies above `MAX_EXP`, so the clamp can be reached. The 4-bit reading counter wraps within a short directed run. A batch of four full-scale readings fills the 10-bit sum exactly. The window references are also placed so that both the upper and the lower inclusive bound are hit exactly.

// File: rtl/meas_accum.sv
module meas_accum #(
  parameter int VAL_W   = 16,
  parameter int MAX_EXP = 7,
  parameter int CNT_W   = 16,
  localparam int EXP_W  = (MAX_EXP < 1) ? 1 : $clog2(MAX_EXP + 1),
  localparam int SUM_W  = VAL_W + MAX_EXP,
  localparam int RD_W   = MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             sample_vld,
  input  logic [VAL_W-1:0] sample_val,
  input  logic [EXP_W-1:0] num_exp,
  input  logic [SUM_W-1:0] sum_ref,
  input  logic [SUM_W-1:0] sum_margin,
  input  logic [VAL_W-1:0] avg_ref,
  input  logic [VAL_W-1:0] avg_margin,
  output logic             batch_done,
  output logic [SUM_W-1:0] sum_out,
  output logic [VAL_W-1:0] avg_out,
  output logic             sum_pass,
  output logic             sum_fail,
  output logic             avg_pass,
  output logic             avg_fail,
  output logic [CNT_W-1:0] meas_count
);

  function automatic logic in_win(input logic [SUM_W-1:0] v,
                                  input logic [SUM_W-1:0] r,
                                  input logic [SUM_W-1:0] m);
    logic [SUM_W:0] vm, rm;
    vm = {1'b0, v} + {1'b0, m};
    rm = {1'b0, r} + {1'b0, m};
    return (vm >= {1'b0, r}) && ({1'b0, v} <= rm);
  endfunction

  logic [SUM_W-1:0] acc_q, acc_nxt;
  logic [RD_W-1:0]  rd_cnt, rd_last;
  logic [EXP_W-1:0] exp_eff;
  logic [VAL_W-1:0] avg_nxt;
  logic             take, last, s_ok, a_ok;

  assign exp_eff = (num_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : num_exp;
  assign rd_last = (RD_W'(1) << exp_eff) - RD_W'(1);
  assign take    = sample_vld & ~restart;
  assign last    = take & (rd_cnt >= rd_last);
  assign acc_nxt = acc_q + SUM_W'(sample_val);
  assign avg_nxt = VAL_W'(acc_nxt >> exp_eff);
  assign s_ok    = in_win(acc_nxt, sum_ref, sum_margin);
  assign a_ok    = in_win(SUM_W'(avg_nxt), SUM_W'(avg_ref), SUM_W'(avg_margin));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      rd_cnt     <= '0;
      batch_done <= 1'b0;
      sum_out    <= '0;
      avg_out    <= '0;
      sum_pass   <= 1'b0;
      sum_fail   <= 1'b0;
      avg_pass   <= 1'b0;
      avg_fail   <= 1'b0;
      meas_count <= '0;
    end else begin
      batch_done <= 1'b0;
      if (restart) begin
        acc_q  <= '0;
        rd_cnt <= '0;
      end else if (take) begin
        meas_count <= meas_count + CNT_W'(1);
        if (last) begin
          acc_q      <= '0;
          rd_cnt     <= '0;
          sum_out    <= acc_nxt;
          avg_out    <= avg_nxt;
          batch_done <= 1'b1;
          sum_pass   <= sum_pass | s_ok;
          sum_fail   <= sum_fail | ~s_ok;
          avg_pass   <= avg_pass | a_ok;
          avg_fail   <= avg_fail | ~a_ok;
        end else begin
          acc_q  <= acc_nxt;
          rd_cnt <= rd_cnt + RD_W'(1);
        end
      end
    end
  end

endmodule

module meas_accum_chk #(
  parameter int VAL_W = 16,
  parameter int SUM_W = 23,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             sample_vld,
  input logic             batch_done,
  input logic [SUM_W-1:0] sum_out,
  input logic [VAL_W-1:0] avg_out,
  input logic             sum_pass,
  input logic             sum_fail,
  input logic             avg_pass,
  input logic             avg_fail,
  input logic [CNT_W-1:0] meas_count
);

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> $past(sample_vld && !restart));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !batch_done |-> ($stable(sum_out) && $stable(avg_out)));

  // R3
  avg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |-> (SUM_W'(avg_out) <= sum_out));

  // R5
  sum_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sum_pass) || $rose(sum_fail)) |-> batch_done);

  // R6
  avg_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(avg_pass) || $rose(avg_fail)) |-> batch_done);

  // R7
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_pass || sum_fail || avg_pass || avg_fail) |=>
      ((sum_pass >= $past(sum_pass)) && (sum_fail >= $past(sum_fail)) &&
       (avg_pass >= $past(avg_pass)) && (avg_fail >= $past(avg_fail))));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !restart) |=> (meas_count == CNT_W'($past(meas_count) + 1'b1)));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!batch_done && $stable(meas_count)));

endmodule

bind meas_accum meas_accum_chk #(.VAL_W(VAL_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .sample_vld(sample_vld),
  .batch_done(batch_done), .sum_out(sum_out), .avg_out(avg_out),
  .sum_pass(sum_pass), .sum_fail(sum_fail), .avg_pass(avg_pass),
  .avg_fail(avg_fail), .meas_count(meas_count)
);

// File: tb/meas_accum_tb.sv
module meas_accum_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VAL_W = 8, MAX_EXP = 2, CNT_W = 4;
  localparam int EXP_W = 2, SUM_W = VAL_W + MAX_EXP;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, sample_vld = 1'b0;
  logic [VAL_W-1:0] sample_val = '0, avg_ref = '0, avg_margin = '0;
  logic [EXP_W-1:0] num_exp = '0;
  logic [SUM_W-1:0] sum_ref = '0, sum_margin = '0;
  logic batch_done, sum_pass, sum_fail, avg_pass, avg_fail;
  logic [SUM_W-1:0] sum_out;
  logic [VAL_W-1:0] avg_out;
  logic [CNT_W-1:0] meas_count;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  meas_accum #(.VAL_W(VAL_W), .MAX_EXP(MAX_EXP), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sample_vld(sample_vld),
    .sample_val(sample_val), .num_exp(num_exp), .sum_ref(sum_ref),
    .sum_margin(sum_margin), .avg_ref(avg_ref), .avg_margin(avg_margin),
    .batch_done(batch_done), .sum_out(sum_out), .avg_out(avg_out),
    .sum_pass(sum_pass), .sum_fail(sum_fail), .avg_pass(avg_pass),
    .avg_fail(avg_fail), .meas_count(meas_count)
  );

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    sample_vld = 1'b1;
    sample_val = VAL_W'(v);
    @(negedge clk);
    sample_vld = 1'b0;
    exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
  endtask

  task automatic flags(input string tag, input int sp, input int sf, input int ap, input int af);
    check({tag, " sum_pass"}, int'(sum_pass), sp);
    check({tag, " sum_fail"}, int'(sum_fail), sf);
    check({tag, " avg_pass"}, int'(avg_pass), ap);
    check({tag, " avg_fail"}, int'(avg_fail), af);
  endtask

  task automatic t_reset;
    check("R1 done", int'(batch_done), 0);
    check("R1 sum", int'(sum_out), 0);
    check("R1 avg", int'(avg_out), 0);
    check("R1 count", int'(meas_count), 0);
    flags("R1", 0, 0, 0, 0);
  endtask

  task automatic t_pair;
    num_exp = 2'd1; sum_ref = 30; sum_margin = 0; avg_ref = 15; avg_margin = 0;
    push(10);
    check("R2 no early done", int'(batch_done), 0);
    push(20);
    check("R2 done", int'(batch_done), 1);
    check("R2 sum", int'(sum_out), 30);
    check("R3 avg", int'(avg_out), 15);
    flags("R5 R6 exact", 1, 0, 1, 0);
    check("R9 count", int'(meas_count), exp_cnt);
  endtask

  task automatic t_quad;
    num_exp = 2'd2; sum_ref = 30; sum_margin = 3; avg_ref = 8; avg_margin = 1;
    push(5); push(6); push(7);
    check("R2 three of four", int'(batch_done), 0);
    push(9);
    check("R2 sum quad", int'(sum_out), 27);
    check("R3 avg truncated", int'(avg_out), 6);
    flags("R5 lower bound R6 miss", 1, 0, 1, 1);
  endtask

  task automatic t_single;
    num_exp = 2'd0; sum_ref = 100; sum_margin = 100; avg_ref = 255; avg_margin = 54;
    push(200);
    check("R2 single done", int'(batch_done), 1);
    check("R2 single sum", int'(sum_out), 200);
    check("R5 upper bound", int'(sum_fail), 0);
    sum_ref = 5; sum_margin = 4;
    push(0);
    check("R5 below window", int'(sum_fail), 1);
    check("R3 avg zero", int'(avg_out), 0);
  endtask

  task automatic t_restart;
    num_exp = 2'd1;
    push(50);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    flags("R8 R7 flags kept", 1, 1, 1, 1);
    check("R8 count kept", int'(meas_count), exp_cnt);
    check("R8 sum_out kept", int'(sum_out), 0);
    push(1);
    check("R8 batch realigned", int'(batch_done), 0);
    push(2);
    check("R8 done after restart", int'(batch_done), 1);
    check("R8 partial dropped", int'(sum_out), 3);
    check("R3 avg after restart", int'(avg_out), 1);
  endtask

  task automatic t_collide;
    num_exp = 2'd0;
    @(negedge clk); restart = 1'b1; sample_vld = 1'b1; sample_val = 77;
    @(negedge clk); restart = 1'b0; sample_vld = 1'b0;
    check("R8 collide no done", int'(batch_done), 0);
    check("R8 collide count", int'(meas_count), exp_cnt);
    check("R8 collide sum", int'(sum_out), 3);
  endtask

  task automatic t_clamp;
    num_exp = 2'd3;
    push(255); push(255); push(255);
    check("R4 clamp not early", int'(batch_done), 0);
    push(255);
    check("R4 clamp done", int'(batch_done), 1);
    check("R4 clamp sum", int'(sum_out), 1020);
    check("R4 clamp avg", int'(avg_out), 255);
  endtask

  task automatic t_wrap_hold;
    num_exp = 2'd0;
    push(4);
    check("R9 wrap", int'(meas_count), 0);
    check("R9 wrap expect", exp_cnt, 0);
    @(negedge clk);
    check("R10 done one cycle", int'(batch_done), 0);
    check("R10 sum held", int'(sum_out), 4);
    check("R10 avg held", int'(avg_out), 4);
    flags("R7 still sticky", 1, 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_quad();
    t_single();
    t_restart();
    t_collide();
    t_clamp();
    t_wrap_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule